// File: doc/BRIEF.md
# Non-Restoring Integer Square Root Array

This block takes an unsigned 8-bit radicand and returns its integer square root together with the remainder left over. It works digit by digit: the radicand is cut into bit pairs, and the pairs are consumed from the most significant end. Each row of the array produces one root bit. A row subtracts a trial value, which is the partial root found so far with binary `01` appended, from the running remainder with the next bit pair shifted in. The row's own final borrow is the select line for every cell in that row. When the row borrows, the old remainder passes through unchanged. Otherwise the difference is passed on. No row ever adds the trial value back.

The array is built from controlled subtract-or-pass cells. Cells whose trial bit or borrow input is a constant use reduced logic. A parameter places a register after every row, so the block accepts a new operand on every cycle and returns each result a fixed number of cycles later. With that parameter cleared, the array is purely combinational. A second parameter appends zero bit pairs below the radicand, which adds rows and produces fractional root bits.

Top module: `nra_sqrt`

## Requirements
- R1: With `FRAC_BITS`=0, `out_root` equals floor(sqrt(radicand)) for every 8-bit radicand.
- R2: `out_rem` equals the radicand (scaled by 4^FRAC_BITS) minus `out_root` squared.
- R3: `out_rem` never exceeds 2·`out_root`. For example, radicand 143 gives root 11 and remainder 22.
- R4: A row whose subtraction of {partial root, `01`} from {remainder, next pair} borrows emits root bit 0 and keeps its remainder. A row that does not borrow emits root bit 1 and passes the difference on. For example, 0x5D gives root 1001 (9) with remainder 12.
- R5: With `PIPELINED`=1, one operand can be accepted every cycle. `out_valid` rises exactly ROWS = `INT_BITS`+`FRAC_BITS` cycles after the matching `in_valid` (4 at defaults), and results leave in issue order.
- R6: Synchronous active-high `rst` clears every stage's valid bit. `out_valid` is low after reset, and operands that were in flight produce no result.
- R7: With `PIPELINED`=0, the result appears in the same cycle as the operand, and `out_valid` follows `in_valid`.
- R8: With `FRAC_BITS`=F, `out_root` has 4+F bits and equals floor(sqrt(radicand·4^F)). For example, 93 with F=4 gives 154 (1001.1010 in binary) with remainder 92.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand strobe |
| in_radicand | input | 2·INT_BITS | Unsigned radicand |
| out_valid | output | 1 | Result strobe |
| out_root | output | ROWS | Root (integer bits above FRAC_BITS fraction bits) |
| out_rem | output | ROWS+1 | Final remainder |

## Verification
Suppose one row chooses the wrong select, for example by passing the difference when it should hold. The root bit from that row flips, and every later row then works on a wrong remainder. The error reaches the ports when that operand completes, ROWS cycles after issue. It shows as a root that is not the floor square root, or as a remainder outside 0..2·root. A fault in the valid shift shows as a result arriving one cycle early or late. It can also show as a spurious result after reset, at the first cycle in which that stage would have fired.

// File: rtl/nra_sqrt_pkg.sv
package nra_sqrt_pkg;

    // Output pair of one controlled subtract-or-pass cell.
    typedef struct packed {
        logic diff;
        logic borrow;
    } csm_out_t;

    // Full cell: the borrow ripples regardless of the select;
    // the select chooses the kept bit or the difference bit.
    function automatic csm_out_t csm_eval(input logic x, input logic y,
                                          input logic b, input logic u);
        csm_out_t o;
        o.borrow = (~x & y) | (~x & b) | (y & b);
        o.diff   = u ? x : (x ^ y ^ b);
        return o;
    endfunction

    // Number of rows for a given integer and fraction root width.
    function automatic int root_rows(input int int_bits, input int frac_bits);
        return int_bits + frac_bits;
    endfunction

endpackage

// File: rtl/nra_csm_full.sv
module nra_csm_full
    import nra_sqrt_pkg::*;
(
    input  logic x_i,
    input  logic y_i,
    input  logic b_i,
    input  logic u_i,
    output logic d_o,
    output logic bo_o
);
    csm_out_t res;

    always_comb res = csm_eval(x_i, y_i, b_i, u_i);

    assign d_o  = res.diff;
    assign bo_o = res.borrow;
endmodule

// File: rtl/nra_csm_lsb.sv
// Reduced cell for the lowest position: subtrahend bit is 1, no borrow in.
module nra_csm_lsb (
    input  logic x_i,
    input  logic u_i,
    output logic d_o,
    output logic bo_o
);
    assign bo_o = ~x_i;
    assign d_o  = u_i ? x_i : ~x_i;
endmodule

// File: rtl/nra_csm_pass.sv
// Reduced cell for positions whose subtrahend bit is always 0.
module nra_csm_pass (
    input  logic x_i,
    input  logic b_i,
    input  logic u_i,
    output logic d_o,
    output logic bo_o
);
    assign bo_o = ~x_i & b_i;
    assign d_o  = u_i ? x_i : (x_i ^ b_i);
endmodule

// File: rtl/nra_csm_row.sv
// One row of cells: subtract trial from minuend, and let the row's final
// borrow select between the old value and the difference.
module nra_csm_row #(
    parameter int W = 3
) (
    input  logic [W-1:0] minuend_i,
    input  logic [W-1:0] trial_i,
    output logic [W-1:0] result_o,
    output logic         borrow_o
);
    logic [W:1] bchain;
    logic       sel;

    assign sel      = bchain[W];
    assign borrow_o = bchain[W];

    for (genvar p = 0; p < W; p++) begin : g_cell
        if (p == 0) begin : g_lsb
            nra_csm_lsb u_cell (
                .x_i (minuend_i[p]),
                .u_i (sel),
                .d_o (result_o[p]),
                .bo_o(bchain[p+1])
            );
        end else if (p == 1 || p == W - 1) begin : g_pass
            nra_csm_pass u_cell (
                .x_i (minuend_i[p]),
                .b_i (bchain[p]),
                .u_i (sel),
                .d_o (result_o[p]),
                .bo_o(bchain[p+1])
            );
        end else begin : g_full
            nra_csm_full u_cell (
                .x_i (minuend_i[p]),
                .y_i (trial_i[p]),
                .b_i (bchain[p]),
                .u_i (sel),
                .d_o (result_o[p]),
                .bo_o(bchain[p+1])
            );
        end
    end

    // Trial bits at the reduced positions are constant by construction.
    logic unused_trial_bits;
    assign unused_trial_bits = ^{trial_i[W-1], trial_i[1:0]};
endmodule

// File: rtl/nra_stage.sv
// Row IDX of the array plus its optional output register.
module nra_stage #(
    parameter int ROWS = 4,
    parameter int IDX  = 0,
    parameter bit PIPE = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              v_i,
    input  logic [ROWS:0]     rem_i,
    input  logic [ROWS-1:0]   root_i,
    input  logic [2*ROWS-1:0] rad_i,
    output logic              v_o,
    output logic [ROWS:0]     rem_o,
    output logic [ROWS-1:0]   root_o,
    output logic [2*ROWS-1:0] rad_o
);
    localparam int W = IDX + 3;

    logic [W-1:0]      minuend;
    logic [W-1:0]      trial;
    logic [W-1:0]      row_res;
    logic              row_borrow;
    logic [ROWS+1:0]   trial_full;
    logic [ROWS:0]     rem_n;
    logic [ROWS-1:0]   root_n;
    logic [2*ROWS-1:0] rad_n;

    assign trial_full = {root_i, 2'b01};
    assign trial      = trial_full[W-1:0];
    assign minuend    = {rem_i[IDX:0], rad_i[2*ROWS-1 -: 2]};

    nra_csm_row #(.W(W)) u_row (
        .minuend_i(minuend),
        .trial_i  (trial),
        .result_o (row_res),
        .borrow_o (row_borrow)
    );

    always_comb begin
        rem_n            = '0;
        rem_n[IDX+1:0]   = row_res[IDX+1:0];
        root_n           = {root_i[ROWS-2:0], ~row_borrow};
        rad_n            = rad_i << 2;
    end

    logic unused_stage;
    assign unused_stage = ^{rem_i, root_i, row_res[W-1]};

    if (PIPE) begin : g_reg
        logic              v_q;
        logic [ROWS:0]     rem_q;
        logic [ROWS-1:0]   root_q;
        logic [2*ROWS-1:0] rad_q;

        always_ff @(posedge clk) begin
            if (rst) v_q <= 1'b0;
            else     v_q <= v_i;
            rem_q  <= rem_n;
            root_q <= root_n;
            rad_q  <= rad_n;
        end

        assign v_o    = v_q;
        assign rem_o  = rem_q;
        assign root_o = root_q;
        assign rad_o  = rad_q;

        // R5: the valid bit advances exactly one stage per clock
        p_valid_step_r5: assert property (@(posedge clk) disable iff (rst)
            (!rst && v_i) |=> v_o);
        p_valid_gap_r5: assert property (@(posedge clk) disable iff (rst)
            (!rst && !v_i) |=> !v_o);
        // R6: reset empties this stage
        p_valid_clear_r6: assert property (@(posedge clk)
            rst |=> !v_o);
    end else begin : g_comb
        assign v_o    = v_i;
        assign rem_o  = rem_n;
        assign root_o = root_n;
        assign rad_o  = rad_n;
    end

    // R4: a borrowing row keeps its remainder, a clean row takes the difference
    p_hold_on_borrow_r4: assert property (@(posedge clk) disable iff (rst)
        (v_i && row_borrow) |-> (row_res == minuend));
    p_take_diff_r4: assert property (@(posedge clk) disable iff (rst)
        (v_i && !row_borrow) |-> (row_res == W'(minuend - trial)));
    // R3: the new remainder fits in IDX+2 bits (no more than twice the root)
    p_rem_fits_r3: assert property (@(posedge clk) disable iff (rst)
        v_i |-> (row_res[W-1] == 1'b0));
endmodule

// File: rtl/nra_sqrt.sv
module nra_sqrt
    import nra_sqrt_pkg::*;
#(
    parameter  int INT_BITS  = 4,
    parameter  int FRAC_BITS = 0,
    parameter  bit PIPELINED = 1'b1,
    localparam int ROWS      = root_rows(INT_BITS, FRAC_BITS),
    localparam int RADW      = 2 * ROWS
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    input  logic [2*INT_BITS-1:0] in_radicand,
    output logic                  out_valid,
    output logic [ROWS-1:0]       out_root,
    output logic [ROWS:0]         out_rem
);
    logic            v_a    [0:ROWS];
    logic [ROWS:0]   rem_a  [0:ROWS];
    logic [ROWS-1:0] root_a [0:ROWS];
    logic [RADW-1:0] rad_a  [0:ROWS];

    assign v_a[0]    = in_valid;
    assign rem_a[0]  = '0;
    assign root_a[0] = '0;
    assign rad_a[0]  = RADW'(in_radicand) << (2 * FRAC_BITS);

    for (genvar k = 0; k < ROWS; k++) begin : g_stage
        nra_stage #(.ROWS(ROWS), .IDX(k), .PIPE(PIPELINED)) u_stage (
            .clk   (clk),
            .rst   (rst),
            .v_i   (v_a[k]),
            .rem_i (rem_a[k]),
            .root_i(root_a[k]),
            .rad_i (rad_a[k]),
            .v_o   (v_a[k+1]),
            .rem_o (rem_a[k+1]),
            .root_o(root_a[k+1]),
            .rad_o (rad_a[k+1])
        );
    end

    assign out_valid = v_a[ROWS];
    assign out_root  = root_a[ROWS];
    assign out_rem   = rem_a[ROWS];

    logic unused_rad_tail;
    assign unused_rad_tail = ^rad_a[ROWS];

    // R3: remainder at the output never exceeds twice the root
    p_rem_bound_r3: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_rem <= {out_root, 1'b0}));
endmodule

// File: tb/nra_sqrt_tb.sv
module nra_sqrt_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [7:0] in_rad = '0;

    always #5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    logic       p_v, c_v, f_v;
    logic [3:0] p_root, c_root;
    logic [4:0] p_rem, c_rem;
    logic [7:0] f_root;
    logic [8:0] f_rem;

    nra_sqrt #(.INT_BITS(4), .FRAC_BITS(0), .PIPELINED(1'b1)) u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_radicand(in_rad),
        .out_valid(p_v), .out_root(p_root), .out_rem(p_rem));

    nra_sqrt #(.INT_BITS(4), .FRAC_BITS(0), .PIPELINED(1'b0)) u_dut_comb (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_radicand(in_rad),
        .out_valid(c_v), .out_root(c_root), .out_rem(c_rem));

    nra_sqrt #(.INT_BITS(4), .FRAC_BITS(4), .PIPELINED(1'b1)) u_dut_frac (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_radicand(in_rad),
        .out_valid(f_v), .out_root(f_root), .out_rem(f_rem));

    int checks = 0;
    int fails  = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int isqrt(input int v);
        int r = 0;
        while ((r + 1) * (r + 1) <= v) r++;
        return r;
    endfunction

    typedef struct packed {
        int         cyc;
        logic [7:0] rad;
    } item_t;

    item_t q_p[$];
    item_t q_f[$];

    // Directed table: radicand, root, remainder
    localparam int NV = 8;
    localparam logic [7:0] T_RAD  [NV] = '{8'd0, 8'd1, 8'd3, 8'd4, 8'h5D, 8'd143, 8'd144, 8'd255};
    localparam logic [3:0] T_ROOT [NV] = '{4'd0, 4'd1, 4'd1, 4'd2, 4'd9,  4'd11,  4'd12,  4'd15};
    localparam logic [4:0] T_REM  [NV] = '{5'd0, 5'd0, 5'd2, 5'd0, 5'd12, 5'd22,  5'd0,   5'd30};

    // Output monitors
    always @(negedge clk) begin
        if (!rst) begin
            item_t it;
            int    e, s;
            if (p_v) begin
                if (q_p.size() == 0) chk(1'b0, "R5", "unexpected pipelined result", 1, 0);
                else begin
                    it = q_p.pop_front();
                    e  = isqrt(int'(it.rad));
                    chk(int'(p_root) == e, "R1", "root", int'(p_root), e);
                    chk(int'(p_rem) == int'(it.rad) - e * e, "R2", "remainder", int'(p_rem), int'(it.rad) - e * e);
                    chk(p_rem <= {p_root, 1'b0}, "R3", "remainder bound", int'(p_rem), 2 * int'(p_root));
                    chk(cyc - it.cyc == 4, "R5", "latency", cyc - it.cyc, 4);
                end
            end
            if (f_v) begin
                if (q_f.size() == 0) chk(1'b0, "R5", "unexpected fraction result", 1, 0);
                else begin
                    it = q_f.pop_front();
                    s  = int'(it.rad) * 256;
                    e  = isqrt(s);
                    chk(int'(f_root) == e, "R8", "fraction root", int'(f_root), e);
                    chk(int'(f_rem) == s - e * e, "R8", "fraction remainder", int'(f_rem), s - e * e);
                    chk(cyc - it.cyc == 8, "R5", "fraction latency", cyc - it.cyc, 8);
                end
            end
            chk(c_v == in_valid, "R7", "combinational valid", int'(c_v), int'(in_valid));
            if (in_valid) begin
                e = isqrt(int'(in_rad));
                chk(int'(c_root) == e, "R7", "combinational root", int'(c_root), e);
                chk(int'(c_rem) == int'(in_rad) - e * e, "R7", "combinational remainder", int'(c_rem), int'(in_rad) - e * e);
            end
        end
    end

    task automatic issue(input logic [7:0] r);
        @(posedge clk);
        #1;
        in_valid = 1'b1;
        in_rad   = r;
        q_p.push_back('{cyc, r});
        q_f.push_back('{cyc, r});
    endtask

    task automatic idle();
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        #1_000_000;
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        bit seen;
        // Reset with garbage on the inputs (R6)
        rst = 1'b1;
        in_valid = 1'b1;
        in_rad = 8'hAA;
        repeat (3) @(posedge clk);
        #1 in_valid = 1'b0;
        @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk(!p_v, "R6", "pipelined valid after reset", int'(p_v), 0);
        chk(!f_v, "R6", "fraction valid after reset", int'(f_v), 0);

        // Table walk, checked on the combinational array (R1 R2 R4)
        for (int i = 0; i < NV; i++) begin
            issue(T_RAD[i]);
            @(negedge clk);
            chk(c_root == T_ROOT[i], "R4", "table root", int'(c_root), int'(T_ROOT[i]));
            chk(c_rem == T_REM[i], "R2", "table remainder", int'(c_rem), int'(T_REM[i]));
        end
        idle();

        // All radicands with bubbles, then back-to-back descending (R1 R5)
        for (int i = 0; i < 256; i++) begin
            issue(8'(i));
            if (i % 5 == 4) idle();
        end
        for (int i = 255; i >= 0; i--) issue(8'(i));
        idle();
        repeat (12) idle();
        chk(q_p.size() == 0, "R5", "pipelined results outstanding", q_p.size(), 0);
        chk(q_f.size() == 0, "R5", "fraction results outstanding", q_f.size(), 0);

        // Fractional root of 0x5D (R8)
        issue(8'h5D);
        idle();
        seen = 1'b0;
        for (int i = 0; i < 20 && !seen; i++) begin
            @(negedge clk);
            if (f_v) begin
                seen = 1'b1;
                chk(f_root == 8'd154, "R8", "root of 0x5D with 4 fraction bits", int'(f_root), 154);
                chk(f_rem == 9'd92, "R8", "remainder of 0x5D with 4 fraction bits", int'(f_rem), 92);
            end
        end
        chk(seen, "R8", "fraction result arrived", int'(seen), 1);
        repeat (4) idle();

        // Reset with operands in flight (R6)
        issue(8'd50);
        issue(8'd60);
        issue(8'd70);
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        rst = 1'b1;
        q_p.delete();
        q_f.delete();
        @(negedge clk);
        chk(!p_v, "R6", "pipelined valid during reset", int'(p_v), 0);
        @(posedge clk);
        #1 rst = 1'b0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            chk(!p_v, "R6", "flushed pipelined operand emerged", int'(p_v), 0);
            chk(!f_v, "R6", "flushed fraction operand emerged", int'(f_v), 0);
        end

        finish_run();
    end
endmodule